// File: doc/BRIEF.md
# Addressed I2C slave with command pointer

This block is the serial front end of a register-mapped I/O expander. It watches an I2C bus whose SCL and SDA lines have already been brought into the local clock domain. It pulls SDA low only when it has to answer. It recognises a 7-bit device address that is made of four fixed bits and three strap pins, so that eight such devices can share one bus.

In a write transfer, the first byte after the address is a command byte. Its top bit selects auto-increment and its low six bits select a register number. Each later byte of the transfer goes out on a simple register-file port as an address, data and a one-cycle write strobe. A read transfer returns the byte at the current register number, most significant bit first. The command stays in place across a repeated START, so the usual sequence is a write of the command followed by a repeated START and a read. Whether the register number advances from byte to byte is chosen by each command byte.

Top module: `i2c_ptr_slave`

## Requirements
- R1: When the 7 bits after a START equal {FIXED_ADDR (default 4'b0100), strap[2:0]}, the block holds SDA low during the ninth SCL clock (acknowledge).
- R2: On an address mismatch the block never pulls SDA low and makes no write until the next START. The command pointer is left as it was.
- R3: In a write transfer, the byte after the address is the command. Bit 7 is the auto-increment flag and bits 5:0 are the register number, which appears on reg_addr. Bit 6 has no effect.
- R4: Each data byte after the command raises reg_we for exactly one clock, with reg_wdata equal to the byte and reg_addr equal to the current register number.
- R5: With the flag set, the register number increases by one after each data byte written or read, and wraps from 63 to 0.
- R6: With the flag clear, the register number stays the same through every data byte.
- R7: When bit 0 of the address byte is 1 (read), the byte reg_rdata[reg_addr] is loaded on the SCL falling edge that ends the acknowledge and is shifted out MSB first. A master ACK loads the next byte.
- R8: After the master NACKs a read byte, the block releases SDA and stays released until STOP or START.
- R9: A repeated START or a STOP keeps the command. A new transfer after a STOP reads from the stored register number.
- R10: rst_n low clears the command (reg_addr = 0, flag clear) at once, without a clock, and releases SDA.
- R11: sda_oe changes only while SCL is low. SDA is only ever pulled low and never driven high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Synchronized SCL line level |
| sda_i | input | 1 | Synchronized SDA line level |
| sda_oe | output | 1 | 1 pulls SDA low |
| strap | input | 3 | Low three address bits |
| reg_addr | output | 6 | Current register number |
| reg_wdata | output | 8 | Write data |
| reg_we | output | 1 | One-clock write strobe |
| reg_rdata | input | 8 | Read data for reg_addr |

## Verification
Writes are tried with the flag set, with the flag clear while bit 6 is set, and with the pointer starting at 63. Together these tell advancing from holding, show that bit 6 does not act as the flag, and show that the pointer wraps. Reads are tried after a repeated START and again after a STOP, with the flag on and off. These separate data loading and pointer advance from the keeping of the command. A near-miss address shows that matching depends on the straps. A NACK followed by extra clocks shows that the block has stopped driving SDA.

// File: rtl/i2c_ptr_slave.sv
module i2c_ptr_slave #(
  parameter logic [3:0] FIXED_ADDR = 4'b0100
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  input  logic [2:0] strap,
  output logic [5:0] reg_addr,
  output logic [7:0] reg_wdata,
  output logic       reg_we,
  input  logic [7:0] reg_rdata
);
  typedef enum logic [3:0] {
    S_IDLE, S_ADDR, S_AACK, S_CMD, S_CACK, S_WDAT, S_WACK, S_RDAT, S_RACK, S_IGN
  } st_t;

  st_t        st;
  logic       scl_q, sda_q;
  logic [3:0] cnt;
  logic [7:0] sh, osh;
  logic       rw, cmd_ai, ack_drv, rd_drv, mack;
  logic [5:0] ptr;

  wire rise  = !scl_q && scl_i;
  wire fall  = scl_q && !scl_i;
  wire start = scl_q && scl_i && sda_q && !sda_i;
  wire stop  = scl_q && scl_i && !sda_q && sda_i;
  wire hit   = sh[7:1] == {FIXED_ADDR, strap};

  assign sda_oe   = ack_drv | (rd_drv & ~osh[7]);
  assign reg_addr = ptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; scl_q <= 1'b1; sda_q <= 1'b1; cnt <= '0;
      sh <= '0; osh <= '0; rw <= 1'b0; cmd_ai <= 1'b0; ptr <= '0;
      ack_drv <= 1'b0; rd_drv <= 1'b0; mack <= 1'b0;
      reg_we <= 1'b0; reg_wdata <= '0;
    end else begin
      scl_q  <= scl_i;
      sda_q  <= sda_i;
      reg_we <= 1'b0;
      if (reg_we && cmd_ai) ptr <= ptr + 6'd1;
      if (start) begin
        st <= S_ADDR; cnt <= '0; ack_drv <= 1'b0; rd_drv <= 1'b0;
      end else if (stop) begin
        st <= S_IDLE; ack_drv <= 1'b0; rd_drv <= 1'b0;
      end else begin
        case (st)
          S_ADDR, S_CMD, S_WDAT: begin
            if (rise) begin
              sh  <= {sh[6:0], sda_i};
              cnt <= cnt + 4'd1;
            end else if (fall && cnt == 4'd8) begin
              if (st == S_ADDR) begin
                if (hit) begin
                  rw <= sh[0]; ack_drv <= 1'b1; st <= S_AACK;
                end else st <= S_IGN;
              end else if (st == S_CMD) begin
                cmd_ai <= sh[7]; ptr <= sh[5:0]; ack_drv <= 1'b1; st <= S_CACK;
              end else begin
                reg_we <= 1'b1; reg_wdata <= sh; ack_drv <= 1'b1; st <= S_WACK;
              end
            end
          end
          S_AACK, S_CACK, S_WACK: begin
            if (fall) begin
              ack_drv <= 1'b0;
              cnt     <= '0;
              if (st == S_AACK && rw) begin
                osh <= reg_rdata; rd_drv <= 1'b1; st <= S_RDAT;
              end else if (st == S_AACK) st <= S_CMD;
              else st <= S_WDAT;
            end
          end
          S_RDAT: begin
            if (rise) cnt <= cnt + 4'd1;
            else if (fall) begin
              if (cnt == 4'd8) begin
                rd_drv <= 1'b0;
                st     <= S_RACK;
                if (cmd_ai) ptr <= ptr + 6'd1;
              end else osh <= {osh[6:0], 1'b1};
            end
          end
          S_RACK: begin
            if (rise) mack <= !sda_i;
            else if (fall) begin
              if (mack) begin
                osh <= reg_rdata; rd_drv <= 1'b1; cnt <= '0; st <= S_RDAT;
              end else st <= S_IGN;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

module i2c_ptr_slave_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_i,
  input logic       sda_oe,
  input logic       reg_we,
  input logic [5:0] reg_addr,
  input logic       ai,
  input logic       idle
);
  p_oe_scl_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !$past(scl_i));
  p_we_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> !reg_we);
  p_we_scl_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |-> !scl_i);
  p_ptr_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && ai) |=> reg_addr == 6'($past(reg_addr) + 6'd1));
  p_ptr_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && !ai) |=> $stable(reg_addr));
  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    idle |-> !sda_oe);
endmodule

bind i2c_ptr_slave i2c_ptr_slave_chk chk_i (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_oe(sda_oe), .reg_we(reg_we),
  .reg_addr(reg_addr), .ai(cmd_ai), .idle(st == S_IDLE)
);

// File: tb/i2c_ptr_slave_tb.sv
`timescale 1ns/1ps
module i2c_ptr_slave_tb_top;
  logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, m_low = 1'b0;
  logic [2:0] strap = 3'b101;
  logic sda, sda_oe, reg_we;
  logic [5:0] reg_addr;
  logic [7:0] reg_wdata, reg_rdata;
  logic [7:0] mem [64];
  int nchk = 0, nfail = 0, nwe = 0, nviol = 0;
  localparam logic [6:0] DEV = 7'b0100101;

  always #10 clk = ~clk;
  assign sda = ~(m_low | sda_oe);
  assign reg_rdata = mem[reg_addr];

  i2c_ptr_slave dut_i (.clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda), .sda_oe(sda_oe),
    .strap(strap), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_we(reg_we),
    .reg_rdata(reg_rdata));

  always @(posedge clk) if (reg_we) begin mem[reg_addr] <= reg_wdata; nwe <= nwe + 1; end
  always @(sda_oe) if (scl && rst_n) nviol++;

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic w(input int n = 4); repeat (n) @(negedge clk); endtask
  task automatic i_start(); m_low = 0; w(); scl = 1; w(); m_low = 1; w(); scl = 0; w(); endtask
  task automatic i_stop(); m_low = 1; w(); scl = 1; w(); m_low = 0; w(8); endtask
  task automatic wbit(input logic b); m_low = ~b; w(); scl = 1; w(8); scl = 0; w(); endtask
  task automatic rbit(output logic b); m_low = 0; w(); scl = 1; w(4); b = sda; w(4); scl = 0; w(); endtask
  task automatic wbyte(input logic [7:0] d, output logic ackn);
    for (int i = 7; i >= 0; i--) wbit(d[i]);
    rbit(ackn);
  endtask
  task automatic rbyte(output logic [7:0] d, input logic ack);
    for (int i = 7; i >= 0; i--) rbit(d[i]);
    wbit(~ack);
  endtask

  task automatic set_cmd(input logic [7:0] c, input string req);
    logic a;
    i_start(); wbyte({DEV, 1'b0}, a); chk({req, " addr ack"}, a, 0);
    wbyte(c, a); chk({req, " cmd ack"}, a, 0);
  endtask

  task automatic t_reset();
    chk("R10 reset addr", reg_addr, 0); chk("R10 reset oe", sda_oe, 0); chk("R10 reset we", reg_we, 0);
  endtask

  task automatic t_write_ai();
    logic a;
    set_cmd(8'h85, "R1");
    chk("R3 pointer from cmd", reg_addr, 5);
    wbyte(8'hA1, a); wbyte(8'hB2, a); wbyte(8'hC3, a); chk("R4 data ack", a, 0);
    i_stop();
    chk("R4 mem5", mem[5], 8'hA1); chk("R5 mem6", mem[6], 8'hB2); chk("R5 mem7", mem[7], 8'hC3);
    chk("R5 final ptr", reg_addr, 8);
  endtask

  task automatic t_write_noai();
    logic a; int n0;
    n0 = nwe;
    set_cmd(8'h4A, "R3");
    wbyte(8'h11, a); wbyte(8'h22, a); i_stop();
    chk("R6 mem10 last byte", mem[10], 8'h22); chk("R6 ptr held", reg_addr, 10);
    chk("R3 bit6 no advance mem11", mem[11], 11 * 7 + 3);
    chk("R4 strobe count", nwe - n0, 2);
  endtask

  task automatic t_mismatch();
    logic a; int n0;
    n0 = nwe;
    i_start(); wbyte({DEV ^ 7'h01, 1'b0}, a); chk("R2 no ack", a, 1);
    wbyte(8'h83, a); wbyte(8'h55, a); chk("R2 no data ack", a, 1); i_stop();
    chk("R2 no write", nwe - n0, 0); chk("R2 ptr kept", reg_addr, 10);
  endtask

  task automatic t_read_ai();
    logic a; logic [7:0] d;
    set_cmd(8'h85, "R7");
    i_start(); wbyte({DEV, 1'b1}, a); chk("R1 read addr ack", a, 0);
    rbyte(d, 1); chk("R7 byte0", d, 8'hA1);
    rbyte(d, 1); chk("R7 byte1", d, 8'hB2);
    rbyte(d, 0); chk("R8 byte2", d, 8'hC3);
    rbit(a); chk("R8 released after nack", a, 1);
    i_stop(); chk("R5 read ptr", reg_addr, 8);
  endtask

  task automatic t_read_after_stop();
    logic a; logic [7:0] d;
    set_cmd(8'h0A, "R9"); i_stop();
    i_start(); wbyte({DEV, 1'b1}, a);
    rbyte(d, 1); chk("R9 read after stop", d, 8'h22);
    rbyte(d, 0); chk("R6 read no advance", d, 8'h22);
    i_stop(); chk("R9 ptr kept", reg_addr, 10);
  endtask

  task automatic t_wrap();
    logic a;
    set_cmd(8'hBF, "R5");
    wbyte(8'h77, a); wbyte(8'h88, a); i_stop();
    chk("R5 mem63", mem[63], 8'h77); chk("R5 wrap mem0", mem[0], 8'h88); chk("R5 wrap ptr", reg_addr, 1);
  endtask

  task automatic t_async_reset();
    set_cmd(8'h9C, "R10"); i_stop();
    chk("R10 pre", reg_addr, 28);
    @(negedge clk); #3 rst_n = 0; #1;
    chk("R10 async clear", reg_addr, 0); chk("R10 oe low", sda_oe, 0);
    w(); rst_n = 1; w();
  endtask

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = 8'(i * 7 + 3);
    w(); t_reset(); rst_n = 1; w();
    t_write_ai(); t_write_noai(); t_mismatch(); t_read_ai();
    t_read_after_stop(); t_wrap(); t_async_reset();
    chk("R11 oe change with scl high", nviol, 0);
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    #3000000;
    nchk++; nfail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule